// File: doc/BRIEF.md
# Configuration Header Register File

This block holds the 256-byte configuration header of a single bus function. An upstream configuration agent presents a write or read strobe, a byte address, an access length of one, two or four bytes and 32 bits of write data. Reads return a little-endian word. Writes are applied lane by lane, and each byte decides for itself whether it accepts data. The rule depends on whether the header is an endpoint or a bridge, which is fixed by a parameter. Identity bytes, base address type bits and bridge defaults are loaded from parameters at reset.

Dword writes to an implemented base address slot, or to the expansion ROM slot, go through a formatting path. It clears the address bits below the slot size and puts back the type bits. In the ROM slot it keeps the enable bit instead. Two pulse outputs tell the address decoder that it must recompute its windows: one when the command register was written, and one with one bit per base slot. For a bridge header, the secondary bus number is driven out continuously.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, bytes 0x00-0x03 hold vendor then device id (little-endian), 0x08-0x0B hold the 32-bit revision/class parameter, 0x0E the header type, 0x2C-0x2F subsystem vendor then subsystem id, 0x3D the interrupt pin, each implemented base slot holds its type bits, rdata is 0, and every other byte is 0 except the bridge defaults of R11.
- R2: A read strobe loads rdata on the next clock edge with the bytes at addr, addr+1 and so on in little-endian order; len 1 or 2 zeroes the upper bytes; any len other than 1 or 2 means 4; a read in the same cycle as a write returns the old contents.
- R3: A 4-byte read at 0xFD or 0xFE returns 2 bytes, and a 4-byte or 2-byte read at 0xFF returns 1 byte.
- R4: In an endpoint header (type 0x00 or 0x80), byte writes to 0x00-0x03, 0x08-0x0B, 0x0E, 0x10-0x27, 0x2C-0x33 and 0x3D are ignored.
- R5: In a bridge header (type 0x01 or 0x81), byte writes to 0x00-0x03, 0x08-0x0B, 0x0E, 0x2C-0x2F, 0x38-0x3B and 0x3D are ignored; 0x10-0x37 are otherwise writable.
- R6: A 4-byte write at 0x10+4k to implemented slot k (k<6 for an endpoint, k<2 for a bridge) stores (data AND NOT(size-1)) OR type and raises bar_upd bit k for one cycle.
- R7: A 4-byte write at the ROM slot (0x30 endpoint, 0x38 bridge) with a nonzero ROM size stores data AND (NOT(size-1) OR 1) and raises bar_upd bit 6 for one cycle.
- R8: Other writes store data byte i at addr+i for i below the length; bytes that would fall past 0xFF are dropped, with no wrap.
- R9: On a write, byte 0x05 keeps only bits 2:0, byte 0x06 clears bits 2:0 and byte 0x07 clears bits 2:1.
- R10: A write whose byte range overlaps 0x04-0x05 raises cmd_upd for one cycle; other writes do not.
- R11: A bridge resets to command 0x06, status 0xA0, latency timer 0x10, header type 0x81 and secondary status 0xA0 at 0x1E, and sec_bus follows byte 0x19; an endpoint drives sec_bus as 0.
- R12: A 4-byte write that is unaligned, or that targets a slot of size 0, follows the byte rules of R4, R5 and R8 and leaves bar_upd at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| len | input | 3 | Access length: 1, 2, otherwise 4 |
| wdata | input | 32 | Write data, lowest byte goes to addr |
| rdata | output | 32 | Read data, held until the next read |
| cmd_upd | output | 1 | Pulse: command register written |
| bar_upd | output | 7 | Pulse per base slot, bit 6 is the ROM slot |
| sec_bus | output | 8 | Secondary bus number (bridge only) |

## Verification
A write lands in the byte registers at the clock edge that samples the strobe. cmd_upd and bar_upd are high for exactly the cycle that follows that edge. Read data appears after the edge that samples rd and then holds. The bench drives each strobe for one cycle from the falling edge and samples pulses and read data at the next falling edge, so every result is looked at in the one cycle it is due. Stored contents are always checked through a later read and never by looking inside the block.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int NBYTE     = 256;
  localparam int BAR_SLOTS = 6;
  localparam int ROM_SLOT  = 6;

  localparam logic [7:0] CMD_HI_KEEP = 8'h07;
  localparam logic [7:0] STS_LO_KEEP = 8'hF8;
  localparam logic [7:0] STS_HI_KEEP = 8'hF9;

  typedef enum logic {HDR_ENDPOINT = 1'b0, HDR_BRIDGE = 1'b1} hdr_kind_e;

  function automatic hdr_kind_e kind_of(input logic [7:0] hdr);
    return (hdr[6:0] == 7'h01) ? HDR_BRIDGE : HDR_ENDPOINT;
  endfunction

  // any length other than 1 or 2 is treated as a dword
  function automatic logic [2:0] len_bytes(input logic [2:0] l);
    case (l)
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic bit byte_ro(input hdr_kind_e k, input int a);
    bit ro;
    ro = (a <= 3) || (a >= 8 && a <= 11) || (a == 14) ||
         (a >= 44 && a <= 47) || (a == 61);
    if (k == HDR_ENDPOINT)
      ro = ro || (a >= 16 && a <= 39) || (a >= 48 && a <= 51);
    else
      ro = ro || (a >= 56 && a <= 59);
    return ro;
  endfunction

  function automatic logic [7:0] keep_mask(input int a);
    case (a)
      5:       return CMD_HI_KEEP;
      6:       return STS_LO_KEEP;
      7:       return STS_HI_KEEP;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/cfg_byte.sv
module cfg_byte
  import cfg_pkg::*;
#(
  parameter logic [7:0] RST_VAL   = 8'h00,
  parameter bit         READ_ONLY = 1'b0,
  parameter logic [7:0] KEEP      = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       g_we,
  input  logic [7:0] g_d,
  input  logic       b_we,
  input  logic [7:0] b_d,
  output logic [7:0] q
);
  logic       ld;
  logic [7:0] q_r, q_nxt;

  always_comb begin
    ld    = b_we | (g_we & ~READ_ONLY);
    q_nxt = b_we ? b_d : (g_d & KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= RST_VAL;
    else if (ld) q_r <= q_nxt;
  end

  assign q = q_r;

  generate
    if (READ_ONLY) begin : g_ro_chk
      // R4 and R5: a protected byte moves only through the slot formatting path
      a_r4_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !b_we |=> $stable(q_r));
    end
  endgenerate
endmodule

// File: rtl/cfg_bar_path.sv
module cfg_bar_path
  import cfg_pkg::*;
#(
  parameter bit                      BRIDGE   = 1'b0,
  parameter logic [BAR_SLOTS*32-1:0] BAR_SIZE = '0,
  parameter logic [BAR_SLOTS*32-1:0] BAR_TYPE = '0,
  parameter logic [31:0]             ROM_SIZE = 32'h0
) (
  input  logic                wr,
  input  logic [7:0]          addr,
  input  logic [2:0]          len,
  input  logic [31:0]         wdata,
  output logic                hit,
  output logic [ROM_SLOT:0]   sel,
  output logic [31:0]         val
);
  localparam int         NBAR_USED = BRIDGE ? 2 : BAR_SLOTS;
  localparam logic [7:0] ROM_OFS   = BRIDGE ? 8'h38 : 8'h30;

  logic        is_dw;
  logic [31:0] cand [ROM_SLOT+1];

  assign is_dw = (len_bytes(len) == 3'd4);

  generate
    for (genvar k = 0; k < BAR_SLOTS; k++) begin : g_slot
      localparam logic [31:0] SZ = BAR_SIZE[k*32 +: 32];
      localparam logic [31:0] TY = BAR_TYPE[k*32 +: 32];
      localparam bit          ON = (k < NBAR_USED) && (SZ != 32'h0);
      localparam logic [7:0]  OFS = 8'(16 + 4*k);
      assign sel[k]  = ON && wr && is_dw && (addr == OFS);
      assign cand[k] = (wdata & ~(SZ - 32'd1)) | TY;
    end
  endgenerate

  assign sel[ROM_SLOT]  = (ROM_SIZE != 32'h0) && wr && is_dw && (addr == ROM_OFS);
  assign cand[ROM_SLOT] = wdata & (~(ROM_SIZE - 32'd1) | 32'd1);

  always_comb begin
    val = '0;
    for (int k = 0; k <= ROM_SLOT; k++)
      if (sel[k]) val = cand[k];
  end

  assign hit = |sel;
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd,
  input  logic [7:0]         addr,
  input  logic [2:0]         len,
  input  logic [NBYTE*8-1:0] cfg_flat,
  output logic [31:0]        rdata
);
  logic [7:0]  a1, a2, a3;
  logic [7:0]  b0, b1, b2, b3;
  logic [2:0]  sz;
  logic [31:0] asm_w, rdata_q, rdata_nxt;

  always_comb begin
    a1 = addr + 8'd1;
    a2 = addr + 8'd2;
    a3 = addr + 8'd3;
    b0 = cfg_flat[{addr, 3'b000} +: 8];
    b1 = cfg_flat[{a1,   3'b000} +: 8];
    b2 = cfg_flat[{a2,   3'b000} +: 8];
    b3 = cfg_flat[{a3,   3'b000} +: 8];
    sz = len_bytes(len);
    if (sz == 3'd4 && addr > 8'hFC) sz = 3'd2;
    if (sz == 3'd2 && addr == 8'hFF) sz = 3'd1;
    case (sz)
      3'd1:    asm_w = {24'h0, b0};
      3'd2:    asm_w = {16'h0, b1, b0};
      default: asm_w = {b3, b2, b1, b0};
    endcase
    rdata_nxt = rd ? asm_w : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_nxt;
  end

  assign rdata = rdata_q;

  // R2: a single-byte read leaves the upper bytes clear
  a_r2_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && len == 3'd1) |=> (rdata[31:8] == 24'h0));
  // R3: a dword read at the last byte shrinks to one byte
  a_r3_top_fallback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && len == 3'd4 && addr == 8'hFF) |=> (rdata[31:8] == 24'h0));
endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_pkg::*;
#(
  parameter logic [7:0]              HDR_TYPE      = 8'h00,
  parameter logic [15:0]             VENDOR_ID     = 16'hA5C3,
  parameter logic [15:0]             DEVICE_ID     = 16'h7E01,
  parameter logic [31:0]             CLASS_REV     = 32'h0200_0001,
  parameter logic [15:0]             SUBSYS_VENDOR = 16'h5A5A,
  parameter logic [15:0]             SUBSYS_ID     = 16'h0042,
  parameter logic [7:0]              INT_PIN       = 8'h01,
  parameter logic [BAR_SLOTS*32-1:0] BAR_SIZE      = {128'h0, 32'h0000_0020, 32'h0000_1000},
  parameter logic [BAR_SLOTS*32-1:0] BAR_TYPE      = {128'h0, 32'h0000_0001, 32'h0000_0000},
  parameter logic [31:0]             ROM_SIZE      = 32'h0000_8000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [7:0]        addr,
  input  logic [2:0]        len,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              cmd_upd,
  output logic [ROM_SLOT:0] bar_upd,
  output logic [7:0]        sec_bus
);
  localparam hdr_kind_e KIND      = kind_of(HDR_TYPE);
  localparam bit        IS_BRIDGE = (KIND == HDR_BRIDGE);
  localparam int        NBAR_USED = IS_BRIDGE ? 2 : BAR_SLOTS;

  function automatic logic [7:0] rst_val(input int j);
    logic [7:0] v;
    v = 8'h00;
    case (j)
      0:  v = VENDOR_ID[7:0];
      1:  v = VENDOR_ID[15:8];
      2:  v = DEVICE_ID[7:0];
      3:  v = DEVICE_ID[15:8];
      8:  v = CLASS_REV[7:0];
      9:  v = CLASS_REV[15:8];
      10: v = CLASS_REV[23:16];
      11: v = CLASS_REV[31:24];
      14: v = HDR_TYPE;
      44: v = SUBSYS_VENDOR[7:0];
      45: v = SUBSYS_VENDOR[15:8];
      46: v = SUBSYS_ID[7:0];
      47: v = SUBSYS_ID[15:8];
      61: v = INT_PIN;
      default: v = 8'h00;
    endcase
    for (int k = 0; k < NBAR_USED; k++)
      if (BAR_SIZE[k*32 +: 32] != 32'h0 && j >= 16 + 4*k && j < 20 + 4*k)
        v = BAR_TYPE[k*32 + 8*(j - 16 - 4*k) +: 8];
    if (IS_BRIDGE) begin
      if (j == 4)  v = 8'h06;
      if (j == 6)  v = 8'hA0;
      if (j == 13) v = 8'h10;
      if (j == 30) v = 8'hA0;
    end
    return v;
  endfunction

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [2:0]         cnt;
  logic               bar_hit;
  logic [ROM_SLOT:0]  bar_sel;
  logic [31:0]        bar_val;
  logic [NBYTE*8-1:0] cfg_flat;

  assign cnt = len_bytes(len);

  cfg_bar_path #(
    .BRIDGE   (IS_BRIDGE),
    .BAR_SIZE (BAR_SIZE),
    .BAR_TYPE (BAR_TYPE),
    .ROM_SIZE (ROM_SIZE)
  ) u_bar (
    .wr    (wr),
    .addr  (addr),
    .len   (len),
    .wdata (wdata),
    .hit   (bar_hit),
    .sel   (bar_sel),
    .val   (bar_val)
  );

  generate
    for (genvar j = 0; j < NBYTE; j++) begin : g_byte
      localparam int W = j / 4;
      localparam int L = j % 4;
      logic [8:0] off;
      logic       g_we, b_we;
      logic [7:0] g_d;
      logic [7:0] q;
      assign off  = 9'(j) - {1'b0, addr};
      assign g_we = wr && !bar_hit && (off < {6'h0, cnt});
      assign g_d  = wdata[{off[1:0], 3'b000} +: 8];
      assign b_we = bar_hit && (addr[7:2] == 6'(W));
      cfg_byte #(
        .RST_VAL   (rst_val(j)),
        .READ_ONLY (byte_ro(KIND, j)),
        .KEEP      (keep_mask(j))
      ) u_b (
        .clk  (clk),
        .rst_n(rst_s),
        .g_we (g_we),
        .g_d  (g_d),
        .b_we (b_we),
        .b_d  (bar_val[8*L +: 8]),
        .q    (q)
      );
      assign cfg_flat[8*j +: 8] = q;
    end
  endgenerate

  cfg_read_mux u_rd (
    .clk      (clk),
    .rst_n    (rst_s),
    .rd       (rd),
    .addr     (addr),
    .len      (len),
    .cfg_flat (cfg_flat),
    .rdata    (rdata)
  );

  // change pulses
  logic [8:0]        end_a;
  logic              cmd_nxt, cmd_q;
  logic [ROM_SLOT:0] bar_nxt, bar_q;

  always_comb begin
    end_a   = {1'b0, addr} + {6'h0, cnt};
    cmd_nxt = wr && (addr < 8'h06) && (end_a > 9'h004);
    bar_nxt = bar_sel;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      cmd_q <= 1'b0;
      bar_q <= '0;
    end else begin
      cmd_q <= cmd_nxt;
      bar_q <= bar_nxt;
    end
  end

  assign cmd_upd = cmd_q;
  assign bar_upd = bar_q;
  assign sec_bus = IS_BRIDGE ? cfg_flat[8*25 +: 8] : 8'h00;

  // R10: the command pulse only follows a write
  a_r10_cmd_after_write: assert property (@(posedge clk) disable iff (!rst_s)
    cmd_upd |-> $past(wr));
  // R6 and R7: at most one slot is reported per write
  a_r6_bar_onehot: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(bar_upd));
  // R7: the slot pulses only follow a write
  a_r7_bar_after_write: assert property (@(posedge clk) disable iff (!rst_s)
    (bar_upd != '0) |-> $past(wr));

  generate
    if (BAR_SIZE[31:0] != 32'h0) begin : g_bar0_chk
      // R6: after a slot-0 write the bits below the size are the type bits
      a_r6_bar0_type: assert property (@(posedge clk) disable iff (!rst_s)
        bar_upd[0] |-> ((cfg_flat[8*16 +: 32] & (BAR_SIZE[31:0] - 32'd1)) ==
                        (BAR_TYPE[31:0] & (BAR_SIZE[31:0] - 32'd1))));
    end
  endgenerate
endmodule

// File: tb/cfg_header_regs_test.sv
module cfg_header_regs_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, sel, wr, rd;
  logic [7:0]  addr;
  logic [2:0]  len;
  logic [31:0] wdata;
  logic [31:0] rdata_e, rdata_b;
  logic        cmd_e, cmd_b;
  logic [6:0]  bar_e, bar_b;
  logic [7:0]  sec_e, sec_b;

  cfg_header_regs uut (
    .clk(clk), .rst_n(rst_n), .wr(wr && !sel), .rd(rd && !sel),
    .addr(addr), .len(len), .wdata(wdata),
    .rdata(rdata_e), .cmd_upd(cmd_e), .bar_upd(bar_e), .sec_bus(sec_e));

  cfg_header_regs #(
    .HDR_TYPE (8'h81),
    .BAR_SIZE ({160'h0, 32'h0000_0100}),
    .BAR_TYPE ({160'h0, 32'h0000_0000}),
    .ROM_SIZE (32'h0000_0800)
  ) uut_br (
    .clk(clk), .rst_n(rst_n), .wr(wr && sel), .rd(rd && sel),
    .addr(addr), .len(len), .wdata(wdata),
    .rdata(rdata_b), .cmd_upd(cmd_b), .bar_upd(bar_b), .sec_bus(sec_b));

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic       cmd_seen;
  logic [6:0] bar_seen;

  typedef struct packed {
    logic        br;
    logic        w;
    logic [7:0]  wa;
    logic [2:0]  wl;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [2:0]  rl;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'h00, 3'd4, 32'h7E01A5C3, 8'd1},  // R1
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'h08, 3'd4, 32'h02000001, 8'd1},  // R1
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'h2C, 3'd4, 32'h00425A5A, 8'd1},  // R1
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'h14, 3'd4, 32'h00000001, 8'd1},  // R1
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'h02, 3'd2, 32'h00007E01, 8'd2},  // R2
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'h3D, 3'd1, 32'h00000001, 8'd2},  // R2
    '{1'b0, 1'b1, 8'h10, 3'd4, 32'hFFFFFFFF,   8'h10, 3'd4, 32'hFFFFF000, 8'd6},  // R6
    '{1'b0, 1'b1, 8'h14, 3'd4, 32'h0000ABCD,   8'h14, 3'd4, 32'h0000ABC1, 8'd6},  // R6
    '{1'b0, 1'b1, 8'h30, 3'd4, 32'h12345679,   8'h30, 3'd4, 32'h12340001, 8'd7},  // R7
    '{1'b0, 1'b1, 8'h18, 3'd4, 32'hDEADBEEF,   8'h18, 3'd4, 32'h00000000, 8'd12}, // R12
    '{1'b0, 1'b1, 8'h00, 3'd4, 32'hFFFFFFFF,   8'h00, 3'd4, 32'h7E01A5C3, 8'd4},  // R4
    '{1'b0, 1'b1, 8'h04, 3'd4, 32'hFFFFFFFF,   8'h04, 3'd4, 32'hF9F807FF, 8'd9},  // R9
    '{1'b0, 1'b1, 8'h3C, 3'd4, 32'h11223344,   8'h3C, 3'd4, 32'h11220144, 8'd8},  // R8
    '{1'b0, 1'b1, 8'hFE, 3'd4, 32'hAABBCCDD,   8'hFC, 3'd4, 32'hCCDD0000, 8'd8},  // R8
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'hFE, 3'd4, 32'h0000CCDD, 8'd3},  // R3
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'hFF, 3'd4, 32'h000000CC, 8'd3},  // R3
    '{1'b0, 1'b0, 8'h00, 3'd4, 32'h0,          8'hFD, 3'd4, 32'h0000DD00, 8'd3},  // R3
    '{1'b0, 1'b1, 8'h41, 3'd2, 32'h00005566,   8'h40, 3'd4, 32'h00556600, 8'd8},  // R8
    '{1'b0, 1'b1, 8'h12, 3'd4, 32'hFFFFFFFF,   8'h10, 3'd4, 32'hFFFFF000, 8'd12}, // R12
    '{1'b0, 1'b1, 8'h31, 3'd1, 32'h000000FF,   8'h30, 3'd4, 32'h12340001, 8'd4},  // R4
    '{1'b0, 1'b1, 8'h0C, 3'd2, 32'h0000BEEF,   8'h0C, 3'd4, 32'h0000BEEF, 8'd2},  // R2
    '{1'b1, 1'b0, 8'h00, 3'd4, 32'h0,          8'h04, 3'd4, 32'h00A00006, 8'd11}, // R11
    '{1'b1, 1'b0, 8'h00, 3'd4, 32'h0,          8'h0C, 3'd4, 32'h00811000, 8'd11}, // R11
    '{1'b1, 1'b0, 8'h00, 3'd4, 32'h0,          8'h1C, 3'd4, 32'h00A00000, 8'd11}, // R11
    '{1'b1, 1'b1, 8'h30, 3'd4, 32'hFFFFFFFF,   8'h30, 3'd4, 32'hFFFFFFFF, 8'd5},  // R5
    '{1'b1, 1'b1, 8'h38, 3'd4, 32'h00001235,   8'h38, 3'd4, 32'h00001001, 8'd7},  // R7
    '{1'b1, 1'b1, 8'h3A, 3'd1, 32'h000000FF,   8'h38, 3'd4, 32'h00001001, 8'd5},  // R5
    '{1'b1, 1'b1, 8'h14, 3'd4, 32'h12345678,   8'h14, 3'd4, 32'h12345678, 8'd12}  // R12
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic s, input logic [7:0] a, input logic [2:0] l,
                       input logic [31:0] d);
    @(negedge clk);
    sel = s; wr = 1'b1; addr = a; len = l; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    cmd_seen = s ? cmd_b : cmd_e;
    bar_seen = s ? bar_b : bar_e;
  endtask

  task automatic do_rd(input logic s, input logic [7:0] a, input logic [2:0] l,
                       output logic [31:0] q);
    @(negedge clk);
    sel = s; rd = 1'b1; addr = a; len = l;
    @(negedge clk);
    rd = 1'b0;
    q = s ? rdata_b : rdata_e;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] q;
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; rd = 1'b0;
    addr = 8'h00; len = 3'd4; wdata = 32'h0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check("R1 rdata after reset", rdata_e, 32'h0);
    check("R11 endpoint sec_bus", {24'h0, sec_e}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].w) do_wr(VEC[i].br, VEC[i].wa, VEC[i].wl, VEC[i].wd);
      do_rd(VEC[i].br, VEC[i].ra, VEC[i].rl, q);
      checks++;
      if (q !== VEC[i].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d: actual %08h expected %08h",
                 VEC[i].req, i, q, VEC[i].exp);
      end
    end

    // R2: read and write in the same cycle returns the old contents
    @(negedge clk);
    sel = 1'b0; wr = 1'b1; rd = 1'b1; addr = 8'h0C; len = 3'd4; wdata = 32'h11111111;
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    check("R2 same-cycle read", rdata_e, 32'h0000BEEF);
    do_rd(1'b0, 8'h0C, 3'd4, q);
    check("R2 write after same-cycle read", q, 32'h11001111);

    // R10: command pulse
    do_wr(1'b0, 8'h03, 3'd2, 32'h0000_0000);
    check("R10 write overlapping 0x04", {31'h0, cmd_seen}, 32'h1);
    do_wr(1'b0, 8'h06, 3'd2, 32'h0000_0000);
    check("R10 status write", {31'h0, cmd_seen}, 32'h0);
    do_wr(1'b0, 8'h02, 3'd2, 32'h0000_0000);
    check("R10 id write", {31'h0, cmd_seen}, 32'h0);
    do_wr(1'b0, 8'h05, 3'd1, 32'h0000_0001);
    check("R10 command high byte", {31'h0, cmd_seen}, 32'h1);

    // R6, R7, R12: slot pulses
    do_wr(1'b0, 8'h14, 3'd4, 32'h0000_1000);
    check("R6 slot 1 pulse", {25'h0, bar_seen}, 32'h02);
    do_wr(1'b0, 8'h30, 3'd4, 32'h0000_0000);
    check("R7 ROM pulse", {25'h0, bar_seen}, 32'h40);
    do_wr(1'b0, 8'h18, 3'd4, 32'hFFFF_FFFF);
    check("R12 size-0 slot no pulse", {25'h0, bar_seen}, 32'h0);
    do_wr(1'b0, 8'h10, 3'd2, 32'h0000_FFFF);
    check("R12 word write no pulse", {25'h0, bar_seen}, 32'h0);
    do_wr(1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF);
    check("R6 bridge slot 0 pulse", {25'h0, bar_seen}, 32'h01);
    do_rd(1'b1, 8'h10, 3'd4, q);
    check("R6 bridge slot 0 mask", q, 32'hFFFF_FF00);

    // R11: secondary bus number
    do_wr(1'b1, 8'h18, 3'd4, 32'h0007_0500);
    @(negedge clk);
    check("R11 sec_bus", {24'h0, sec_b}, 32'h05);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule